// File: doc/BRIEF.md
# Pipelined Hamming Threshold Comparator

This block decides whether a candidate word is close enough to a stored reference word. Each cycle it may take one candidate. It forms the bitwise difference against the reference, counts the differing positions in a registered adder tree, and flags a match when that count is no greater than a tolerance supplied on the same cycle. A tolerance of zero asks for an exact match.

The count starts at 6-bit leaf groups. Their small sums are combined inside 32-bit segments, and the segment totals are then added to give the word total. A register sits after every adder level, so throughput is one word per clock and latency is fixed. A compile-time option builds an equality-only variant. It has no counter, returns a zero count, and has a single cycle of latency.

Top module: `hamm_thresh_cmp`

## Requirements
- R1: When `out_valid` is high, `out_count` equals the number of bit positions in which the accepted `in_word` differs from the `pattern` sampled with it (0 to WORD_W).
- R2: When `out_valid` is high, `out_match` is 1 exactly when `out_count` is less than or equal to the `threshold` sampled with that word.
- R3: With a threshold of 0, `out_match` is 1 only for a word identical to its pattern. A single differing bit gives 0.
- R4: With default parameters, a word accepted on a rising edge (`in_valid` high) produces `out_valid` high on the 7th rising edge counted from the accepting one, and not earlier.
- R5: A word can be accepted on every cycle. Back-to-back words produce back-to-back results in input order.
- R6: A synchronous active-high `rst` forces `out_valid` and `out_match` low on the next edge and discards every word in flight.
- R7: `out_match` is 0 whenever `out_valid` is 0.
- R8: `pattern` and `threshold` are captured on the accepting edge. Changing them afterwards does not alter that word's result.
- R9: The count and threshold are $clog2(WORD_W+1) bits wide (8 for 128). A threshold of 128 matches even a word that differs in every bit.
- R10: With EXACT_MODE=1, the result follows one edge after acceptance. `out_match` is 1 exactly when word and pattern are equal, `out_count` is 0, and `threshold` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Candidate word present this cycle |
| in_word | input | WORD_W | Candidate word |
| pattern | input | WORD_W | Reference word to compare against |
| threshold | input | CNT_W | Largest mismatch count still accepted |
| out_valid | output | 1 | Result present this cycle |
| out_match | output | 1 | Candidate within tolerance |
| out_count | output | CNT_W | Number of differing bit positions |

## Verification
In the default build, a result is due on the seventh rising edge counting the accepting one. In the exact build, it is due on the first. Every directed case drives inputs just after a falling edge. It then reads the outputs on the falling edge after the sixth rising edge, expecting no result, and on the falling edge after the seventh, expecting the result. The streamed case checks the result for word k at the loop step seven cycles after k was driven. The exact-mode instance is read one falling edge after each word.

// File: rtl/hamm_pkg.sv
package hamm_pkg;

  function automatic int cdiv(input int a, input int b);
    return (a + b - 1) / b;
  endfunction

  // Registered stages: leaf, segment adder levels, word adder levels, compare.
  function automatic int latency_of(input int word_w, input int seg_w,
                                    input int leaf_w, input bit exact);
    if (exact) return 1;
    return 2 + $clog2(cdiv(seg_w, leaf_w)) + $clog2(word_w / seg_w);
  endfunction

endpackage

// File: rtl/hamm_leaf.sv
module hamm_leaf #(
  parameter int W = 6,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  bits_i,
  output logic [CW-1:0] cnt_o
);

  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < W; i++) cnt_o = cnt_o + CW'(bits_i[i]);
  end

endmodule

// File: rtl/hamm_add_tree.sv
module hamm_add_tree #(
  parameter int N_IN  = 6,
  parameter int IN_W  = 3,
  parameter int OUT_W = 6,
  localparam int LVLS = $clog2(N_IN),
  localparam int P    = 1 << LVLS
) (
  input  logic                 clk,
  input  logic [N_IN*IN_W-1:0] in_flat,
  output logic [OUT_W-1:0]     sum_o
);

  for (genvar k = 0; k <= LVLS; k++) begin : g_lvl
    logic [OUT_W-1:0] node [P >> k];
    if (k == 0) begin : g_in
      for (genvar i = 0; i < P; i++) begin : g_pad
        if (i < N_IN) begin : g_real
          assign node[i] = OUT_W'(in_flat[i*IN_W +: IN_W]);
        end else begin : g_zero
          assign node[i] = '0;
        end
      end
    end else begin : g_add
      always_ff @(posedge clk) begin
        for (int i = 0; i < (P >> k); i++)
          node[i] <= g_lvl[k-1].node[2*i] + g_lvl[k-1].node[2*i+1];
      end
    end
  end

  assign sum_o = g_lvl[LVLS].node[0];

endmodule

// File: rtl/hamm_thresh_cmp.sv
module hamm_thresh_cmp #(
  parameter int WORD_W     = 128,
  parameter int SEG_W      = 32,
  parameter int LEAF_W     = 6,
  parameter bit EXACT_MODE = 1'b0,
  localparam int CNT_W     = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  input  logic [WORD_W-1:0] pattern,
  input  logic [CNT_W-1:0]  threshold,
  output logic              out_valid,
  output logic              out_match,
  output logic [CNT_W-1:0]  out_count
);

  localparam int LAT     = hamm_pkg::latency_of(WORD_W, SEG_W, LEAF_W, EXACT_MODE);
  localparam int N_SEG   = WORD_W / SEG_W;
  localparam int LEAF_N  = hamm_pkg::cdiv(SEG_W, LEAF_W);
  localparam int LEAF_CW = $clog2(LEAF_W + 1);
  localparam int SEG_CW  = $clog2(SEG_W + 1);

  if (EXACT_MODE) begin : g_exact
    always_ff @(posedge clk) begin
      out_count <= '0;
      if (rst) begin
        out_valid <= 1'b0;
        out_match <= 1'b0;
      end else begin
        out_valid <= in_valid;
        out_match <= in_valid && (in_word == pattern);
      end
    end
  end else begin : g_tol
    logic [WORD_W-1:0]       diff;
    logic [N_SEG*SEG_CW-1:0] seg_flat;
    logic [CNT_W-1:0]        total;
    logic [LAT-2:0]          vsr;
    logic [CNT_W-1:0]        thr_sr [LAT-1];

    assign diff = in_word ^ pattern;

    for (genvar s = 0; s < N_SEG; s++) begin : g_seg
      logic [LEAF_N*LEAF_W-1:0]  seg_bits;
      logic [LEAF_N*LEAF_CW-1:0] leaf_d;
      logic [LEAF_N*LEAF_CW-1:0] leaf_q;

      assign seg_bits = (LEAF_N*LEAF_W)'(diff[s*SEG_W +: SEG_W]);

      for (genvar j = 0; j < LEAF_N; j++) begin : g_leaf
        hamm_leaf #(.W(LEAF_W)) u_leaf (
          .bits_i (seg_bits[j*LEAF_W +: LEAF_W]),
          .cnt_o  (leaf_d[j*LEAF_CW +: LEAF_CW])
        );
      end

      always_ff @(posedge clk) leaf_q <= leaf_d;

      hamm_add_tree #(.N_IN(LEAF_N), .IN_W(LEAF_CW), .OUT_W(SEG_CW)) u_seg_sum (
        .clk     (clk),
        .in_flat (leaf_q),
        .sum_o   (seg_flat[s*SEG_CW +: SEG_CW])
      );
    end

    hamm_add_tree #(.N_IN(N_SEG), .IN_W(SEG_CW), .OUT_W(CNT_W)) u_word_sum (
      .clk     (clk),
      .in_flat (seg_flat),
      .sum_o   (total)
    );

    always_ff @(posedge clk) begin
      thr_sr[0] <= threshold;
      for (int i = 1; i < LAT - 1; i++) thr_sr[i] <= thr_sr[i-1];
      out_count <= total;
      if (rst) begin
        vsr       <= '0;
        out_valid <= 1'b0;
        out_match <= 1'b0;
      end else begin
        vsr       <= (LAT-1)'({vsr, in_valid});
        out_valid <= vsr[LAT-2];
        out_match <= vsr[LAT-2] && (total <= thr_sr[LAT-2]);
      end
    end
  end

endmodule

// File: rtl/hamm_thresh_cmp_chk.sv
module hamm_thresh_cmp_chk #(
  parameter int WORD_W     = 128,
  parameter int SEG_W      = 32,
  parameter int LEAF_W     = 6,
  parameter bit EXACT_MODE = 1'b0,
  parameter int CNT_W      = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [CNT_W-1:0] threshold,
  input logic             out_valid,
  input logic             out_match,
  input logic [CNT_W-1:0] out_count
);

  localparam int LAT = hamm_pkg::latency_of(WORD_W, SEG_W, LEAF_W, EXACT_MODE);

  logic [LAT-1:0]   v_hist;
  logic [CNT_W-1:0] t_hist [LAT];

  always_ff @(posedge clk) begin
    t_hist[0] <= threshold;
    for (int i = 1; i < LAT; i++) t_hist[i] <= t_hist[i-1];
    if (rst) v_hist <= '0;
    else     v_hist <= LAT'({v_hist, in_valid});
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst) out_valid == v_hist[LAT-1]); // R4
  AST_MATCH_QUIET: assert property (@(posedge clk) disable iff (rst) !out_valid |-> !out_match); // R7
  AST_RESET_FLUSH: assert property (@(posedge clk) rst |=> !out_valid); // R6

  if (EXACT_MODE) begin : g_exact_chk
    AST_EXACT_NO_COUNT: assert property (@(posedge clk) disable iff (rst) out_valid |-> out_count == '0); // R10
  end else begin : g_tol_chk
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst) out_valid |-> out_count <= CNT_W'(WORD_W)); // R1
    AST_TOL_RULE: assert property (@(posedge clk) disable iff (rst) out_valid |-> (out_match == (out_count <= t_hist[LAT-1]))); // R2
    AST_ZERO_DIFF: assert property (@(posedge clk) disable iff (rst) (out_valid && out_count == '0) |-> out_match); // R3
  end

endmodule

bind hamm_thresh_cmp hamm_thresh_cmp_chk #(
  .WORD_W(WORD_W), .SEG_W(SEG_W), .LEAF_W(LEAF_W), .EXACT_MODE(EXACT_MODE), .CNT_W(CNT_W)
) u_chk (.*);

// File: tb/hamm_thresh_cmp_bench.sv
module hamm_thresh_cmp_bench;

  localparam int W   = 128;
  localparam int CW  = 8;
  localparam int LAT = 7;

  typedef struct packed {
    logic [W-1:0]  w;
    logic [W-1:0]  p;
    logic [CW-1:0] t;
    logic [CW-1:0] c;
    logic          m;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{128'h0, 128'h0, 8'd0, 8'd0, 1'b1},
    '{{128{1'b1}}, 128'h0, 8'd127, 8'd128, 1'b0},
    '{{128{1'b1}}, {128{1'b1}}, 8'd0, 8'd0, 1'b1},
    '{128'h1, 128'h0, 8'd0, 8'd1, 1'b0},
    '{128'h1, 128'h0, 8'd1, 8'd1, 1'b1},
    '{128'hF, 128'h0, 8'd3, 8'd4, 1'b0},
    '{{16{8'hA5}}, {16{8'h5A}}, 8'd128, 8'd128, 1'b1},
    '{128'h80000001_80000001_80000001_80000001, 128'h0, 8'd8, 8'd8, 1'b1},
    '{128'h3F, 128'h0, 8'd5, 8'd6, 1'b0},
    '{128'hFFFFFFFF, 128'h0, 8'd32, 8'd32, 1'b1},
    '{128'h0, 128'hFFFFFFFF_00000000_00000000_00000000, 8'd31, 8'd32, 1'b0},
    '{{2{64'h0123456789ABCDEF}}, {64'h0123456789ABCDEF, 64'h0123456789ABCDEE}, 8'd2, 8'd1, 1'b1}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [W-1:0]  in_word = '0;
  logic [W-1:0]  pattern = '0;
  logic [CW-1:0] threshold = '0;
  logic          out_valid, out_match;
  logic [CW-1:0] out_count;
  logic          ex_valid, ex_match;
  logic [CW-1:0] ex_count;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  hamm_thresh_cmp u_hamm_thresh_cmp (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word), .pattern(pattern),
    .threshold(threshold), .out_valid(out_valid), .out_match(out_match), .out_count(out_count)
  );

  hamm_thresh_cmp #(.EXACT_MODE(1'b1)) u_hamm_thresh_cmp_exact (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word), .pattern(pattern),
    .threshold(threshold), .out_valid(ex_valid), .out_match(ex_match), .out_count(ex_count)
  );

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input bit v, input vec_t x);
    in_valid  = v;
    in_word   = x.w;
    pattern   = x.p;
    threshold = x.t;
  endtask

  task automatic run_row(input vec_t x);
    drive(1'b1, x);
    @(negedge clk);
    chk(ex_valid == 1'b1, "R10 exact valid", W'(ex_valid), W'(1));
    chk(ex_match == (x.c == 0), "R10 exact match", W'(ex_match), W'(x.c == 0));
    chk(ex_count == '0, "R10 exact count", W'(ex_count), W'(0));
    in_valid = 1'b0;
    repeat (LAT - 2) @(negedge clk);
    chk(out_valid == 1'b0, "R4 early valid", W'(out_valid), W'(0));
    chk(out_match == 1'b0, "R7 match while idle", W'(out_match), W'(0));
    @(negedge clk);
    chk(out_valid == 1'b1, "R4 valid due", W'(out_valid), W'(1));
    chk(out_count == x.c, "R1 count", W'(out_count), W'(x.c));
    chk(out_match == x.m, "R2 R3 R9 match", W'(out_match), W'(x.m));
  endtask

  initial begin
    repeat (LAT * 4000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    bit seen;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R6 reset valid", W'(out_valid), W'(0));
    chk(out_match == 1'b0, "R6 reset match", W'(out_match), W'(0));
    chk(ex_valid == 1'b0, "R6 reset exact valid", W'(ex_valid), W'(0));
    rst = 1'b0;
    @(negedge clk);

    // Directed table walk, one word at a time (R1 R2 R3 R4 R7 R9 R10)
    for (int r = 0; r < NV; r++) run_row(VEC[r]);

    // Back-to-back stream (R5)
    for (int c = 0; c < NV + LAT; c++) begin
      if (c >= 1 && c <= NV)
        chk(ex_valid && ex_match == (VEC[c-1].c == 0), "R10 stream exact",
            W'(ex_match), W'(VEC[c-1].c == 0));
      if (c >= LAT) begin
        chk(out_valid == 1'b1, "R5 stream valid", W'(out_valid), W'(1));
        chk(out_count == VEC[c-LAT].c, "R5 stream count", W'(out_count), W'(VEC[c-LAT].c));
        chk(out_match == VEC[c-LAT].m, "R5 stream match", W'(out_match), W'(VEC[c-LAT].m));
      end
      if (c < NV) drive(1'b1, VEC[c]);
      else in_valid = 1'b0;
      @(negedge clk);
    end

    // Pattern and threshold sampled on acceptance (R8)
    drive(1'b1, '{128'hF, 128'h0, 8'd4, 8'd0, 1'b0});
    @(negedge clk);
    drive(1'b1, '{128'h1, 128'h0, 8'd0, 8'd0, 1'b0});
    @(negedge clk);
    drive(1'b0, '{128'h0, 128'hF, 8'd127, 8'd0, 1'b0});
    repeat (LAT - 2) @(negedge clk);
    chk(out_valid && out_count == 8'd4, "R8 first count", W'(out_count), W'(4));
    chk(out_match == 1'b1, "R8 first match", W'(out_match), W'(1));
    @(negedge clk);
    chk(out_valid && out_count == 8'd1, "R8 second count", W'(out_count), W'(1));
    chk(out_match == 1'b0, "R8 second match", W'(out_match), W'(0));

    // Threshold ignored in exact mode (R10)
    drive(1'b1, '{128'h3, 128'h0, 8'd128, 8'd0, 1'b0});
    @(negedge clk);
    chk(ex_valid && !ex_match, "R10 threshold ignored", W'(ex_match), W'(0));
    in_valid = 1'b0;
    repeat (LAT) @(negedge clk);

    // Reset discards words in flight (R6)
    drive(1'b1, '{128'h0, 128'h0, 8'd0, 8'd0, 1'b0});
    @(negedge clk);
    drive(1'b1, '{128'h5, 128'h0, 8'd9, 8'd0, 1'b0});
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0 && out_match == 1'b0, "R6 reset flush", W'(out_valid), W'(0));
    rst = 1'b0;
    seen = 1'b0;
    for (int k = 0; k < LAT + 3; k++) begin
      @(negedge clk);
      if (out_valid || out_match) seen = 1'b1;
    end
    chk(!seen, "R6 no result after reset", W'(seen), W'(0));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule